// File: doc/BRIEF.md
# Dual-Rail Parity Serial Link

This block is a point-to-point serial link made of a transmitter and a receiver. A 10-bit word goes out in a framed serial format: a low start bit, the data least significant bit first, and a parity bit that makes the count of ones odd. Every bit is driven on two wires at once, a true wire and a wire that carries its inverse. The receiver checks that the two wires agree as complements, that the parity is odd and that the true wire is back high after the parity bit. Only then does it accept the word.

The receiver side owns the shared bus clock. It builds that clock from the system clock with a divider, and it can hold the clock low to stop the sender. The transmitter moves its wires just after each rising bus clock edge. The receiver samples on each falling edge, through a short synchronizer. After a frame, both ends wait a fixed number of idle bus clock periods before they act again, so a stray low level in that window cannot start a new frame. The wires between the two ends are outside the block: `bus_pos`/`bus_neg` leave the transmitter and `rx_pos`/`rx_neg` enter the receiver, so a board or a bench connects them.

Top module: `dual_rail_link`

## Requirements
- R1: After reset, bus_pos is 1, bus_neg is 0, bus_clk is 0, ready is 1, and data_out, valid and error are all 0.
- R2: A loaded word is sent on bus_pos as 13 bit times: a 0 start bit, then data bits 0 to 9 in that order, then a parity bit chosen so the 11 bits of data plus parity hold an odd number of ones, then a 1 (stop level).
- R3: bus_neg equals the inverse of bus_pos in every system clock cycle.
- R4: bus_pos changes only in the system cycle that follows a rising edge of bus_clk. The receiver samples its lines only at falling edges of bus_clk.
- R5: While stall is low, bus_clk stays high for HALF_CYC system cycles and then low for HALF_CYC system cycles.
- R6: While stall is high, bus_clk does not rise, so a loaded word is not started and bus_pos stays 1.
- R7: A frame with complementary lines, odd parity and a stop level of 1 sets data_out to its data bits, sets valid to 1 and error to 0. valid and error are never both 1.
- R8: A frame in which any captured bit on rx_neg is not the inverse of the same bit on rx_pos sets error to 1 and valid to 0, and leaves data_out unchanged.
- R9: A frame whose 11 captured data and parity bits on rx_pos hold an even number of ones sets error to 1 and valid to 0, and leaves data_out unchanged.
- R10: A frame whose rx_pos is 0 at the falling edge that follows the parity bit sets error to 1 and valid to 0, and leaves data_out unchanged.
- R11: ready returns to 1 only at the 17th rising edge of bus_clk after a load (13 bit times plus GUARD_N = 4 idle edges). The receiver ignores a low rx_pos at the GUARD_N falling edges that follow the stop sample.
- R12: data_out, valid and error change only in the single evaluation cycle after the stop sample, never while a frame is being captured.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | Receiver request to hold the bus clock low |
| data_in | input | DATA_W | Word to transmit |
| load | input | 1 | Accept data_in when ready is 1 |
| ready | output | 1 | Transmitter is idle and can take a word |
| bus_clk | output | 1 | Shared bus clock generated on the receiver side |
| bus_pos | output | 1 | Transmitter true line |
| bus_neg | output | 1 | Transmitter complementary line |
| rx_pos | input | 1 | Receiver true line input |
| rx_neg | input | 1 | Receiver complementary line input |
| data_out | output | DATA_W | Last accepted word |
| valid | output | 1 | Last frame was accepted |
| error | output | 1 | Last frame was rejected |

## Verification
The bench builds the link with HALF_CYC = 4, so one bus bit lasts eight system cycles. A full frame plus its guard then fits in well under 200 system cycles, and stall windows, bit-level sampling and several corrupted frames all fit in one short run. DATA_W and GUARD_N keep their defaults, so the 13-bit frame, the odd-parity rule and the 17-edge turnaround are checked at their real sizes. The receiver lines are normally fed from the transmitter, but the bench can drive them directly. This lets it force complement faults, wrong parity, a missing stop level and a false start inside the guard window.

// File: rtl/link_pkg.sv
package link_pkg;

    // Single-cycle strobes marking bus clock transitions in the system domain
    typedef struct packed {
        logic rise;
        logic fall;
    } bus_edges_t;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_ARMED,
        TX_SEND,
        TX_GUARD
    } tx_state_e;

    typedef enum logic [2:0] {
        RX_HUNT,
        RX_CAP,
        RX_STOP,
        RX_CHECK,
        RX_GUARD
    } rx_state_e;

    // Line levels when no frame is on the wire
    localparam logic IDLE_POS = 1'b1;
    localparam logic IDLE_NEG = 1'b0;

endpackage

// File: rtl/link_sync.sv
module link_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/link_clkgen.sv
module link_clkgen
    import link_pkg::*;
#(
    parameter int HALF_CYC = 500
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       stall,
    output logic       bus_clk,
    output bus_edges_t edges
);
    localparam int              CW   = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [CW-1:0]   LAST = CW'(HALF_CYC - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            bus_clk <= 1'b0;
            edges   <= '0;
        end else begin
            edges <= '0;
            if (cnt == LAST) begin
                if (bus_clk) begin
                    bus_clk    <= 1'b0;
                    edges.fall <= 1'b1;
                    cnt        <= '0;
                end else if (!stall) begin
                    bus_clk    <= 1'b1;
                    edges.rise <= 1'b1;
                    cnt        <= '0;
                end
                // stalled while low: hold count so the rise comes at once on release
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R6: a held-low clock stays low while stall is asserted
    a_r6_stall_holds_low: assert property (@(posedge clk) disable iff (rst)
        (stall && !bus_clk) |=> !bus_clk);
endmodule

// File: rtl/link_tx.sv
module link_tx
    import link_pkg::*;
#(
    parameter int DATA_W  = 10,
    parameter int GUARD_N = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_edges_t        edges,
    input  logic [DATA_W-1:0] data_in,
    input  logic              load,
    output logic              ready,
    output logic              tx_pos,
    output logic              tx_neg
);
    localparam int FRAME_N = DATA_W + 2;            // start + data + parity
    localparam int CW      = $clog2(FRAME_N + 1);
    localparam int GW      = $clog2(GUARD_N + 1);

    tx_state_e          state;
    logic [FRAME_N-1:0] frame;
    logic [CW-1:0]      bit_idx;
    logic [GW-1:0]      guard_cnt;

    assign ready = (state == TX_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= TX_IDLE;
            frame     <= '0;
            bit_idx   <= '0;
            guard_cnt <= '0;
            tx_pos    <= IDLE_POS;
            tx_neg    <= IDLE_NEG;
        end else begin
            case (state)
                TX_IDLE: begin
                    if (load) begin
                        frame <= {~^data_in, data_in, 1'b0};
                        state <= TX_ARMED;
                    end
                end
                TX_ARMED: begin
                    if (edges.rise) begin
                        tx_pos  <= frame[0];
                        tx_neg  <= ~frame[0];
                        bit_idx <= CW'(1);
                        state   <= TX_SEND;
                    end
                end
                TX_SEND: begin
                    if (edges.rise) begin
                        if (bit_idx == CW'(FRAME_N)) begin
                            tx_pos    <= IDLE_POS;
                            tx_neg    <= IDLE_NEG;
                            guard_cnt <= '0;
                            state     <= TX_GUARD;
                        end else begin
                            tx_pos  <= frame[bit_idx];
                            tx_neg  <= ~frame[bit_idx];
                            bit_idx <= bit_idx + 1'b1;
                        end
                    end
                end
                TX_GUARD: begin
                    if (edges.rise) begin
                        if (guard_cnt == GW'(GUARD_N - 1)) state <= TX_IDLE;
                        else guard_cnt <= guard_cnt + 1'b1;
                    end
                end
                default: state <= TX_IDLE;
            endcase
        end
    end

    // R3: the two wires always carry opposite levels
    a_r3_lines_complement: assert property (@(posedge clk) disable iff (rst)
        tx_neg == ~tx_pos);

    // R4: the true wire moves only right after a bus clock rise
    a_r4_move_on_rise: assert property (@(posedge clk) disable iff (rst)
        !$stable(tx_pos) |-> $past(edges.rise));

    // R11: an idle transmitter holds the idle level
    a_r11_idle_when_ready: assert property (@(posedge clk) disable iff (rst)
        ready |-> (tx_pos && !tx_neg));
endmodule

// File: rtl/link_rx.sv
module link_rx
    import link_pkg::*;
#(
    parameter int DATA_W  = 10,
    parameter int GUARD_N = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_edges_t        edges,
    input  logic              line_pos,
    input  logic              line_neg,
    output logic [DATA_W-1:0] data_out,
    output logic              valid,
    output logic              error
);
    localparam int CAP_N = DATA_W + 1;              // data + parity
    localparam int CW    = $clog2(CAP_N);
    localparam int GW    = $clog2(GUARD_N + 1);

    rx_state_e        state;
    logic [CAP_N-1:0] cap_p;
    logic [CAP_N-1:0] cap_n;
    logic [CW-1:0]    bit_idx;
    logic [GW-1:0]    guard_cnt;
    logic             stop_ok;
    logic             frame_ok;

    assign frame_ok = (cap_p == ~cap_n) && (^cap_p) && stop_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= RX_HUNT;
            cap_p     <= '0;
            cap_n     <= '0;
            bit_idx   <= '0;
            guard_cnt <= '0;
            stop_ok   <= 1'b0;
            data_out  <= '0;
            valid     <= 1'b0;
            error     <= 1'b0;
        end else begin
            case (state)
                RX_HUNT: begin
                    if (edges.fall && !line_pos) begin
                        bit_idx <= '0;
                        state   <= RX_CAP;
                    end
                end
                RX_CAP: begin
                    if (edges.fall) begin
                        cap_p <= {line_pos, cap_p[CAP_N-1:1]};
                        cap_n <= {line_neg, cap_n[CAP_N-1:1]};
                        if (bit_idx == CW'(CAP_N - 1)) state <= RX_STOP;
                        else bit_idx <= bit_idx + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (edges.fall) begin
                        stop_ok <= line_pos;
                        state   <= RX_CHECK;
                    end
                end
                RX_CHECK: begin
                    if (frame_ok) begin
                        data_out <= cap_p[DATA_W-1:0];
                        valid    <= 1'b1;
                        error    <= 1'b0;
                    end else begin
                        valid    <= 1'b0;
                        error    <= 1'b1;
                    end
                    guard_cnt <= '0;
                    state     <= RX_GUARD;
                end
                RX_GUARD: begin
                    if (edges.fall) begin
                        if (guard_cnt == GW'(GUARD_N - 1)) state <= RX_HUNT;
                        else guard_cnt <= guard_cnt + 1'b1;
                    end
                end
                default: state <= RX_HUNT;
            endcase
        end
    end

    // R12: results move only out of the evaluation state
    a_r12_update_in_check: assert property (@(posedge clk) disable iff (rst)
        (state != RX_CHECK) |=> ($stable(data_out) && $stable(valid) && $stable(error)));

    // R7/R8: accept and reject flags are exclusive
    a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(valid && error));
endmodule

// File: rtl/dual_rail_link.sv
module dual_rail_link
    import link_pkg::*;
#(
    parameter int DATA_W   = 10,
    parameter int GUARD_N  = 4,
    parameter int HALF_CYC = 500,   // 100 kHz bus clock from a 100 MHz system clock
    parameter int SYNC_N   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stall,
    input  logic [DATA_W-1:0] data_in,
    input  logic              load,
    output logic              ready,
    output logic              bus_clk,
    output logic              bus_pos,
    output logic              bus_neg,
    input  logic              rx_pos,
    input  logic              rx_neg,
    output logic [DATA_W-1:0] data_out,
    output logic              valid,
    output logic              error
);
    bus_edges_t edges;
    logic       pos_s;
    logic       neg_s;

    link_clkgen #(.HALF_CYC(HALF_CYC)) u_clkgen (
        .clk     (clk),
        .rst     (rst),
        .stall   (stall),
        .bus_clk (bus_clk),
        .edges   (edges)
    );

    link_tx #(.DATA_W(DATA_W), .GUARD_N(GUARD_N)) u_tx (
        .clk     (clk),
        .rst     (rst),
        .edges   (edges),
        .data_in (data_in),
        .load    (load),
        .ready   (ready),
        .tx_pos  (bus_pos),
        .tx_neg  (bus_neg)
    );

    link_sync #(.STAGES(SYNC_N), .RST_VAL(IDLE_POS)) u_sync_pos (
        .clk (clk),
        .rst (rst),
        .d   (rx_pos),
        .q   (pos_s)
    );

    link_sync #(.STAGES(SYNC_N), .RST_VAL(IDLE_NEG)) u_sync_neg (
        .clk (clk),
        .rst (rst),
        .d   (rx_neg),
        .q   (neg_s)
    );

    link_rx #(.DATA_W(DATA_W), .GUARD_N(GUARD_N)) u_rx (
        .clk      (clk),
        .rst      (rst),
        .edges    (edges),
        .line_pos (pos_s),
        .line_neg (neg_s),
        .data_out (data_out),
        .valid    (valid),
        .error    (error)
    );
endmodule

// File: tb/test_dual_rail_link.sv
module test_dual_rail_link;
    localparam int DW = 10;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst, stall, load;
    logic [DW-1:0] data_in;
    logic          ready, bus_clk, bus_pos, bus_neg;
    logic [DW-1:0] data_out;
    logic          valid, error;
    logic          inj_en, inj_pos, inj_neg;
    logic          rx_pos, rx_neg;

    assign rx_pos = inj_en ? inj_pos : bus_pos;
    assign rx_neg = inj_en ? inj_neg : bus_neg;

    dual_rail_link #(.DATA_W(DW), .GUARD_N(4), .HALF_CYC(4)) i_dual_rail_link (
        .clk(clk), .rst(rst), .stall(stall), .data_in(data_in), .load(load),
        .ready(ready), .bus_clk(bus_clk), .bus_pos(bus_pos), .bus_neg(bus_neg),
        .rx_pos(rx_pos), .rx_neg(rx_neg), .data_out(data_out),
        .valid(valid), .error(error)
    );

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    // {expected parity bit, data}
    localparam logic [DW:0] VECS [7] = '{
        {1'b1, 10'h000}, {1'b1, 10'h3FF}, {1'b0, 10'h155}, {1'b0, 10'h2AA},
        {1'b0, 10'h001}, {1'b0, 10'h200}, {1'b1, 10'h0F3}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] mk(input logic [DW-1:0] d);
        return {~^d, d, 1'b0};
    endfunction

    task automatic load_word(input logic [DW-1:0] d);
        @(negedge bus_clk);
        @(negedge clk);
        data_in = d;
        load    = 1'b1;
        @(negedge clk);
        load    = 1'b0;
    endtask

    task automatic send_tx(input logic [DW-1:0] d, input logic ep);
        logic [12:0] got_p, got_n, exp_p;
        logic        v0;
        bit          hold_ok;
        exp_p   = {1'b1, ep, d, 1'b0};
        v0      = valid;
        hold_ok = 1'b1;
        load_word(d);
        @(posedge bus_clk);
        for (int i = 0; i < 13; i++) begin
            @(negedge bus_clk);   // sampled at falling edges (R4)
            got_p[i] = bus_pos;
            got_n[i] = bus_neg;
            if (valid !== v0) hold_ok = 1'b0;
        end
        chk(got_p == exp_p, "R2 serial order", int'(got_p), int'(exp_p));
        chk(got_n == ~got_p, "R3 complement", int'(got_n), int'(~got_p));
        chk(hold_ok, "R12 flags steady mid-frame", int'(valid), int'(v0));
        while (!ready) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic send_raw(input logic [11:0] pb, input logic [11:0] nb,
                            input logic stop_p, input bit fake);
        @(negedge bus_clk);
        @(posedge bus_clk);
        @(negedge clk);
        for (int i = 0; i < 12; i++) begin
            inj_pos = pb[i];
            inj_neg = nb[i];
            @(posedge bus_clk);
            @(negedge clk);
        end
        inj_pos = stop_p;
        inj_neg = ~stop_p;
        @(posedge bus_clk);
        @(negedge clk);
        inj_pos = 1'b1;
        inj_neg = 1'b0;
        if (fake) begin
            inj_pos = 1'b0;
            inj_neg = 1'b1;
            @(posedge bus_clk);
            @(negedge clk);
            inj_pos = 1'b1;
            inj_neg = 1'b0;
        end
        repeat (20) @(negedge bus_clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int hi, lo, rises;
        bit quiet;
        rst = 1'b1; stall = 1'b0; load = 1'b0; data_in = '0;
        inj_en = 1'b0; inj_pos = 1'b1; inj_neg = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk(bus_pos === 1'b1 && bus_neg === 1'b0, "R1 idle lines", int'({bus_pos, bus_neg}), 2);
        chk(bus_clk === 1'b0, "R1 bus_clk", int'(bus_clk), 0);
        chk(ready === 1'b1, "R1 ready", int'(ready), 1);
        chk(data_out === '0 && valid === 1'b0 && error === 1'b0, "R1 outputs",
            int'({data_out, valid, error}), 0);

        // R5 bus clock phases
        @(posedge bus_clk);
        @(negedge clk);
        hi = 0;
        while (bus_clk) begin hi++; @(negedge clk); end
        lo = 0;
        while (!bus_clk) begin lo++; @(negedge clk); end
        chk(hi == 4, "R5 high phase", hi, 4);
        chk(lo == 4, "R5 low phase", lo, 4);

        // Vector table walk: R2, R3, R7, R12
        for (int k = 0; k < 7; k++) begin
            send_tx(VECS[k][DW-1:0], VECS[k][DW]);
            chk(data_out == VECS[k][DW-1:0], "R7 data_out", int'(data_out), int'(VECS[k][DW-1:0]));
            chk(valid && !error, "R7 flags", int'({valid, error}), 2);
        end

        // R11 transmitter turnaround: 17 rises from load to ready
        load_word(10'h0AB);
        rises = 0;
        while (!ready) begin
            @(posedge bus_clk);
            rises++;
            repeat (2) @(negedge clk);
        end
        chk(rises == 17, "R11 rises to ready", rises, 17);
        chk(data_out == 10'h0AB, "R7 data_out after turnaround", int'(data_out), 'h0AB);

        // R6 stall holds the bus clock and the sender
        @(negedge clk);
        stall = 1'b1;
        repeat (20) @(negedge clk);
        quiet = 1'b1;
        for (int i = 0; i < 40; i++) begin
            if (bus_clk) quiet = 1'b0;
            @(negedge clk);
        end
        chk(quiet, "R6 clock held low", int'(bus_clk), 0);
        data_in = 10'h123;
        load    = 1'b1;
        @(negedge clk);
        load    = 1'b0;
        quiet   = 1'b1;
        for (int i = 0; i < 40; i++) begin
            if (!bus_pos || ready || bus_clk) quiet = 1'b0;
            @(negedge clk);
        end
        chk(quiet, "R6 sender blocked", int'({bus_pos, ready}), 2);
        stall = 1'b0;
        while (!ready) @(negedge clk);
        repeat (2) @(negedge clk);
        chk(data_out == 10'h123, "R6 frame after release", int'(data_out), 'h123);

        // Receiver fault cases with bench-driven lines
        inj_en = 1'b1;
        send_raw(mk(10'h155), ~mk(10'h155), 1'b1, 1'b0);
        chk(data_out == 10'h155 && valid && !error, "R7 injected good frame",
            int'(data_out), 'h155);

        send_raw(mk(10'h2AA), ~mk(10'h2AA) ^ 12'h020, 1'b1, 1'b0);
        chk(error && !valid, "R8 complement fault flags", int'({valid, error}), 1);
        chk(data_out == 10'h155, "R8 data_out kept", int'(data_out), 'h155);

        send_raw(mk(10'h2AA), ~mk(10'h2AA), 1'b1, 1'b0);
        chk(data_out == 10'h2AA && valid && !error, "R7 recovery after fault",
            int'(data_out), 'h2AA);

        send_raw(mk(10'h0F0) ^ 12'h800, ~(mk(10'h0F0) ^ 12'h800), 1'b1, 1'b0);
        chk(error && !valid, "R9 parity fault flags", int'({valid, error}), 1);
        chk(data_out == 10'h2AA, "R9 data_out kept", int'(data_out), 'h2AA);

        send_raw(mk(10'h0F0), ~mk(10'h0F0), 1'b0, 1'b0);
        chk(error && !valid, "R10 missing stop flags", int'({valid, error}), 1);
        chk(data_out == 10'h2AA, "R10 data_out kept", int'(data_out), 'h2AA);

        // R11 guard: a low pulse right after the stop sample must not start a frame
        send_raw(mk(10'h0F0), ~mk(10'h0F0), 1'b1, 1'b1);
        chk(data_out == 10'h0F0, "R11 false start ignored", int'(data_out), 'h0F0);
        chk(valid && !error, "R11 flags after guard", int'({valid, error}), 2);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule